// File: doc/BRIEF.md
# Deferred Floating-Point Operation Replay Sequencer

This block re-runs floating-point operations that an FPU left pending when it raised a deferred exception. Trap-handling logic loads up to four pending entries into a small in-order store. Each entry is an instruction word and the address it came from. Then it pulses `start_i` together with the current PC, next-PC and status word.

If the store is empty, the trap was precise. The sequencer fetches the one offending instruction from the PC over a fetch handshake and hands it to an external execution unit. If the store is not empty, the sequencer hands the stored entries to the execution unit one after another.

When the sequence ends, the block pulses `done_o` for one cycle. With the pulse it presents the outcome: a new PC and next-PC, an updated status word and a pass/fail bit. The surrounding logic writes these values back.

Top module: `fpq_drain_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fetch_req_o` and `exec_req_o` are 0 and `depth_o` is 0.
- R2: While idle, a `push_i` appends its instruction and address at the tail and increments `depth_o`. A push while the store holds 4 entries is ignored, so `depth_o` stays 4.
- R3: A start with `depth_o` equal to 0 raises `fetch_req_o` with `fetch_addr_o` equal to the PC captured at start. If the fetch answers with `fetch_err_i`=1, the run ends failed, nothing is executed, and PC and next-PC come back unchanged.
- R4: In a precise run, the fetched word is presented on `exec_insn_o`. On success, `pc_o` equals the old next-PC, `npc_o` equals the old next-PC plus 4, and `stat_o` equals the captured status unchanged.
- R5: A precise run whose execution fails ends with `pass_o`=0 and `pc_o`/`npc_o` equal to the captured values.
- R6: A deferred run presents entries strictly from entry 0 upward, with each entry's word and address. It stops after the first entry answered with `exec_ok_i`=0, and no further request follows.
- R7: A deferred run in which every entry succeeds ends with `pass_o`=1. `stat_o` equals the captured status with bits 13:12 and bits 4:0 cleared. PC and next-PC are unchanged.
- R8: A deferred run that fails ends with `pass_o`=0. `stat_o` equals the captured status with only bits 13:12 cleared, so bits 4:0 are kept.
- R9: At the end of every deferred run, `depth_o` returns to 0, whatever the outcome.
- R10: While `busy_o` is 1, `start_i` and `push_i` are ignored: the depth, the request in progress and the entry being presented do not change.
- R11: A request stays high with a stable payload until it is acknowledged. `done_o` is a single-cycle pulse, registered on the edge that accepts the final acknowledge. `busy_o` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Append one pending entry |
| push_insn_i | input | 32 | Instruction word of the pushed entry |
| push_addr_i | input | 32 | Address of the pushed entry |
| depth_o | output | 3 | Number of stored entries |
| start_i | input | 1 | Begin a replay run |
| pc_i | input | 32 | Current PC, captured at start |
| npc_i | input | 32 | Current next-PC, captured at start |
| stat_i | input | 32 | Status word, captured at start |
| busy_o | output | 1 | A run is in progress |
| fetch_req_o | output | 1 | Fetch request for the precise case |
| fetch_addr_o | output | 32 | Fetch address (captured PC) |
| fetch_ack_i | input | 1 | Fetch completed |
| fetch_data_i | input | 32 | Fetched instruction word |
| fetch_err_i | input | 1 | Fetch faulted |
| exec_req_o | output | 1 | Execution request |
| exec_insn_o | output | 32 | Instruction to execute |
| exec_addr_o | output | 32 | Address of that instruction |
| exec_ack_i | input | 1 | Execution finished |
| exec_ok_i | input | 1 | Execution succeeded (valid with ack) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run outcome, valid with done |
| precise_o | output | 1 | The finished run was precise |
| pc_o | output | 32 | Resulting PC |
| npc_o | output | 32 | Resulting next-PC |
| stat_o | output | 32 | Resulting status word |

## Verification
A start is taken at a rising edge. A fetch or execution request is visible in the following cycle, and each acknowledge is consumed on the next rising edge. The final acknowledge produces `done_o` and all result ports in the very next half cycle, and `done_o` drops one cycle later. The bench drives every input at the falling edge and samples at the falling edge after each accepting rising edge. It therefore checks each result in the exact cycle it is due: the request payload while waiting, the absence of a further request after a failure, `done_o` one cycle after the final acknowledge, and the cleared depth at that same point.

// File: rtl/fpq_pkg.sv
// fpq_pkg: shared types for the replay sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package fpq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } fpq_state_e;
endpackage

// File: rtl/fpq_store.sv
// fpq_store: in-order storage of pending operations plus a saturating depth count.
// Assumes: pushes are only taken while the sequencer is idle; clear_i arrives only while busy.
module fpq_store #(
    parameter int DEPTH = 4,
    parameter int XLEN  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [XLEN-1:0]  push_insn_i,
    input  logic [XLEN-1:0]  push_addr_i,
    input  logic             busy_i,
    input  logic             clear_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [XLEN-1:0]  rd_insn_o,
    output logic [XLEN-1:0]  rd_addr_o,
    output logic [CNT_W-1:0] depth_o
);
    logic [CNT_W-1:0] depth_q;
    logic             take;
    logic [XLEN-1:0]  insn_q [DEPTH];
    logic [XLEN-1:0]  addr_q [DEPTH];

    // Accept a push only when idle and not full.
    assign take = push_i && !busy_i && (depth_q < CNT_W'(DEPTH));

    // Depth counter: clear at end of a deferred run, count accepted pushes.
    always_ff @(posedge clk) begin
        if (!rst_n)       depth_q <= '0;
        else if (clear_i) depth_q <= '0;
        else if (take)    depth_q <= depth_q + CNT_W'(1);
    end

    // One register pair per slot, written when the tail points at it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                insn_q[g] <= '0;
                addr_q[g] <= '0;
            end else if (take && (depth_q == CNT_W'(g))) begin
                insn_q[g] <= push_insn_i;
                addr_q[g] <= push_addr_i;
            end
        end
    end

    assign rd_insn_o = insn_q[rd_idx_i];
    assign rd_addr_o = addr_q[rd_idx_i];
    assign depth_o   = depth_q;

    // R2: the count never passes the capacity.
    a_r2_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= CNT_W'(DEPTH));

    // R9: a clear request empties the store on the next cycle.
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (depth_q == '0));

    // R10: nothing changes the count while a run is active unless it is the clear.
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !clear_i) |=> $stable(depth_q));
endmodule

// File: rtl/fpq_ctrl.sv
// fpq_ctrl: run control. Chooses precise or deferred mode at start, drives
// the fetch and execute handshakes, walks the entry index and signals the end.
// Assumes: depth_i is stable while busy; acks are only meaningful while the matching request is high.
module fpq_ctrl #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] depth_i,
    input  logic             fetch_ack_i,
    input  logic             fetch_err_i,
    input  logic             exec_ack_i,
    input  logic             exec_ok_i,
    output logic             busy_o,
    output logic             fetch_req_o,
    output logic             exec_req_o,
    output logic             precise_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             capture_o,
    output logic             load_insn_o,
    output logic             finish_o,
    output logic             finish_ok_o,
    output logic             clear_o
);
    import fpq_pkg::*;

    fpq_state_e       state_q, state_d;
    logic             precise_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_entry;

    // Start is honoured only from idle.
    assign capture_o   = (state_q == ST_IDLE) && start_i;
    assign fetch_req_o = (state_q == ST_FETCH);
    assign exec_req_o  = (state_q == ST_EXEC);
    assign busy_o      = (state_q != ST_IDLE);
    assign load_insn_o = fetch_req_o && fetch_ack_i && !fetch_err_i;
    assign last_entry  = (CNT_W'(idx_q) == depth_i - CNT_W'(1));

    // End-of-run detection: fetch fault, precise execution, failed or last deferred entry.
    always_comb begin
        finish_o    = 1'b0;
        finish_ok_o = 1'b0;
        if (fetch_req_o && fetch_ack_i && fetch_err_i) begin
            finish_o = 1'b1;
        end else if (exec_req_o && exec_ack_i) begin
            if (precise_q || !exec_ok_i || last_entry) begin
                finish_o    = 1'b1;
                finish_ok_o = exec_ok_i;
            end
        end
    end
    assign clear_o = finish_o && !precise_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = (depth_i == '0) ? ST_FETCH : ST_EXEC;
            ST_FETCH: if (fetch_ack_i) state_d = fetch_err_i ? ST_IDLE : ST_EXEC;
            ST_EXEC:  if (finish_o) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, mode and entry index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            precise_q <= 1'b0;
            idx_q     <= '0;
        end else begin
            state_q <= state_d;
            if (capture_o) begin
                precise_q <= (depth_i == '0);
                idx_q     <= '0;
            end else if (exec_req_o && exec_ack_i && !finish_o) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign precise_o = precise_q;
    assign idx_o     = idx_q;

    // R11: an unanswered execute request persists.
    a_r11_exec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req_o && !exec_ack_i) |=> exec_req_o);

    // R11: an unanswered fetch request persists.
    a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_ack_i) |=> fetch_req_o);

    // R11: the two handshakes are never active together.
    a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req_o && exec_req_o));

    // R6: a failed deferred entry is followed by no further request.
    a_r6_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req_o && exec_ack_i && !exec_ok_i) |=> !exec_req_o);

    // R3: fetching happens only in precise runs.
    a_r3_fetch_precise: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> precise_q);
endmodule

// File: rtl/fpq_result.sv
// fpq_result: computes the PC, next-PC and status word written back at the end of a run.
// Assumes: the inputs are the values captured at start; the output is consumed only when a run finishes.
module fpq_result #(
    parameter int XLEN    = 32,
    parameter int QF_LO   = 12,
    parameter int QF_W    = 2,
    parameter int CEXC_LO = 0,
    parameter int CEXC_W  = 5,
    parameter int STEP    = 4,
    localparam logic [XLEN-1:0] QF_MASK   = ((XLEN'(1) << QF_W) - XLEN'(1)) << QF_LO,
    localparam logic [XLEN-1:0] CEXC_MASK = ((XLEN'(1) << CEXC_W) - XLEN'(1)) << CEXC_LO
) (
    input  logic            precise_i,
    input  logic            ok_i,
    input  logic [XLEN-1:0] stat_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] npc_i,
    output logic [XLEN-1:0] stat_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] npc_o
);
    // Write-back selection per mode and outcome.
    always_comb begin
        pc_o   = pc_i;
        npc_o  = npc_i;
        stat_o = stat_i;
        if (precise_i) begin
            if (ok_i) begin
                pc_o  = npc_i;
                npc_o = npc_i + XLEN'(STEP);
            end
        end else if (ok_i) begin
            stat_o = stat_i & ~(QF_MASK | CEXC_MASK);
        end else begin
            stat_o = stat_i & ~QF_MASK;
        end
    end
endmodule

// File: rtl/fpq_drain_seq.sv
// fpq_drain_seq: top of the replay sequencer. Joins the entry store, the run
// control and the write-back logic, and holds the start-time snapshot and the result registers.
// Assumes: the caller loads entries before start and applies the results on done_o.
module fpq_drain_seq #(
    parameter int DEPTH = 4,
    parameter int XLEN  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [XLEN-1:0]  push_insn_i,
    input  logic [XLEN-1:0]  push_addr_i,
    output logic [CNT_W-1:0] depth_o,
    input  logic             start_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  npc_i,
    input  logic [XLEN-1:0]  stat_i,
    output logic             busy_o,
    output logic             fetch_req_o,
    output logic [XLEN-1:0]  fetch_addr_o,
    input  logic             fetch_ack_i,
    input  logic [XLEN-1:0]  fetch_data_i,
    input  logic             fetch_err_i,
    output logic             exec_req_o,
    output logic [XLEN-1:0]  exec_insn_o,
    output logic [XLEN-1:0]  exec_addr_o,
    input  logic             exec_ack_i,
    input  logic             exec_ok_i,
    output logic             done_o,
    output logic             pass_o,
    output logic             precise_o,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  npc_o,
    output logic [XLEN-1:0]  stat_o
);
    logic             capture, load_insn, finish, finish_ok, clear, run_precise;
    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  rd_insn, rd_addr;
    logic [XLEN-1:0]  pc_q, npc_q, stat_q, insn_q;
    logic [XLEN-1:0]  pc_n, npc_n, stat_n;

    fpq_store #(.DEPTH(DEPTH), .XLEN(XLEN)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_insn_i(push_insn_i), .push_addr_i(push_addr_i),
        .busy_i(busy_o), .clear_i(clear), .rd_idx_i(idx),
        .rd_insn_o(rd_insn), .rd_addr_o(rd_addr), .depth_o(depth_o)
    );

    fpq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .depth_i(depth_o),
        .fetch_ack_i(fetch_ack_i), .fetch_err_i(fetch_err_i),
        .exec_ack_i(exec_ack_i), .exec_ok_i(exec_ok_i),
        .busy_o(busy_o), .fetch_req_o(fetch_req_o), .exec_req_o(exec_req_o),
        .precise_o(run_precise), .idx_o(idx), .capture_o(capture),
        .load_insn_o(load_insn), .finish_o(finish), .finish_ok_o(finish_ok),
        .clear_o(clear)
    );

    fpq_result #(.XLEN(XLEN)) u_result (
        .precise_i(run_precise), .ok_i(finish_ok), .stat_i(stat_q),
        .pc_i(pc_q), .npc_i(npc_q),
        .stat_o(stat_n), .pc_o(pc_n), .npc_o(npc_n)
    );

    // Snapshot of PC, next-PC and status at start; fetched word on fetch success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            npc_q  <= '0;
            stat_q <= '0;
            insn_q <= '0;
        end else begin
            if (capture) begin
                pc_q   <= pc_i;
                npc_q  <= npc_i;
                stat_q <= stat_i;
            end
            if (load_insn) insn_q <= fetch_data_i;
        end
    end

    // Result registers and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            pass_o    <= 1'b0;
            precise_o <= 1'b0;
            pc_o      <= '0;
            npc_o     <= '0;
            stat_o    <= '0;
        end else begin
            done_o <= finish;
            if (finish) begin
                pass_o    <= finish_ok;
                precise_o <= run_precise;
                pc_o      <= pc_n;
                npc_o     <= npc_n;
                stat_o    <= stat_n;
            end
        end
    end

    assign fetch_addr_o = pc_q;
    assign exec_insn_o  = run_precise ? insn_q : rd_insn;
    assign exec_addr_o  = run_precise ? pc_q : rd_addr;

    // R11: done is one cycle wide and lands while idle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4: a passing precise run advances by one step past the old next-PC.
    a_r4_precise_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && precise_o && pass_o) |-> (npc_o == pc_o + XLEN'(4)));

    // R7: a passing deferred run leaves the queue flags and exception field clear.
    a_r7_defer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !precise_o && pass_o) |-> (stat_o[13:12] == 2'b00 && stat_o[4:0] == 5'd0));

    // R8: a failing deferred run keeps the exception field.
    a_r8_fail_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !precise_o && !pass_o) |-> (stat_o[13:12] == 2'b00 && stat_o[4:0] == stat_q[4:0]));

    // R9: the store is empty when a deferred run reports.
    a_r9_empty_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !precise_o) |-> (depth_o == '0));

    // R11: the presented operation holds while its request waits.
    a_r11_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req_o && !exec_ack_i) |=> ($stable(exec_insn_o) && $stable(exec_addr_o)));
endmodule

// File: tb/fpq_drain_seq_bench.sv
module fpq_drain_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [31:0] push_insn_i = '0, push_addr_i = '0;
    logic [2:0]  depth_o;
    logic        start_i = 1'b0;
    logic [31:0] pc_i = '0, npc_i = '0, stat_i = '0;
    logic        busy_o, fetch_req_o, exec_req_o;
    logic [31:0] fetch_addr_o, exec_insn_o, exec_addr_o;
    logic        fetch_ack_i = 1'b0, fetch_err_i = 1'b0;
    logic [31:0] fetch_data_i = '0;
    logic        exec_ack_i = 1'b0, exec_ok_i = 1'b0;
    logic        done_o, pass_o, precise_o;
    logic [31:0] pc_o, npc_o, stat_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fpq_drain_seq u_fpq_drain_seq (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_insn_i(push_insn_i), .push_addr_i(push_addr_i),
        .depth_o(depth_o), .start_i(start_i), .pc_i(pc_i), .npc_i(npc_i),
        .stat_i(stat_i), .busy_o(busy_o), .fetch_req_o(fetch_req_o),
        .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i),
        .fetch_data_i(fetch_data_i), .fetch_err_i(fetch_err_i),
        .exec_req_o(exec_req_o), .exec_insn_o(exec_insn_o),
        .exec_addr_o(exec_addr_o), .exec_ack_i(exec_ack_i), .exec_ok_i(exec_ok_i),
        .done_o(done_o), .pass_o(pass_o), .precise_o(precise_o),
        .pc_o(pc_o), .npc_o(npc_o), .stat_o(stat_o)
    );

    // Vector table: pushes attempted, failing position (4 = none), status word.
    localparam int          VN = 8;
    localparam int          VPUSH [VN] = '{0, 0, 1, 2, 3, 4, 6, 4};
    localparam int          VFAIL [VN] = '{4, 0, 4, 1, 4, 0, 3, 4};
    localparam logic [31:0] VSTAT [VN] = '{32'h0000_301F, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                           32'h0000_3015, 32'h1234_3A5F, 32'hFFFF_FFFF,
                                           32'h0000_2008, 32'hABCD_F0F7};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ent_insn(int v, int k);
        return 32'hA000_0000 | (32'(v) << 8) | 32'(k);
    endfunction
    function automatic logic [31:0] ent_addr(int v, int k);
        return 32'h0000_1000 + 32'(v) * 64 + 32'(k) * 4;
    endfunction

    task automatic wait_for(input bit fetch);
        for (int t = 0; t < 20; t++) begin
            if (fetch ? fetch_req_o : exec_req_o) return;
            @(negedge clk);
        end
        chk(fetch ? "R3 fetch request timeout" : "R6 exec request timeout", 32'd0, 32'd1);
    endtask

    task automatic push_n(input int v, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk);
            push_i = 1'b1;
            push_insn_i = ent_insn(v, k);
            push_addr_i = ent_addr(v, k);
        end
        @(negedge clk);
        push_i = 1'b0;
    endtask

    task automatic start_run(input logic [31:0] pc, input logic [31:0] st);
        start_i = 1'b1;
        pc_i = pc;
        npc_i = pc + 32'd4;
        stat_i = st;
        @(negedge clk);
        start_i = 1'b0;
        chk("R11 busy after start", 32'(busy_o), 32'd1);
    endtask

    task automatic run_vec(input int v);
        int n, fa;
        logic [31:0] pc, st, pinsn;
        bit ok_all;
        n = (VPUSH[v] > 4) ? 4 : VPUSH[v];
        fa = VFAIL[v];
        st = VSTAT[v];
        pc = 32'h4000_0000 + 32'(v) * 256;
        pinsn = 32'hC0DE_0000 | 32'(v);
        if (VPUSH[v] > 0) begin
            push_n(v, VPUSH[v]);
            chk("R2 depth after pushes", 32'(depth_o), 32'(n));
        end
        start_run(pc, st);
        if (n == 0) begin
            wait_for(1'b1);
            chk("R3 fetch address", fetch_addr_o, pc);
            fetch_ack_i = 1'b1; fetch_err_i = 1'b0; fetch_data_i = pinsn;
            @(negedge clk);
            fetch_ack_i = 1'b0;
            wait_for(1'b0);
            chk("R4 precise word presented", exec_insn_o, pinsn);
            exec_ack_i = 1'b1; exec_ok_i = (fa != 0);
            @(negedge clk);
            exec_ack_i = 1'b0;
            chk("R11 done after final ack", 32'(done_o), 32'd1);
            chk("R4 precise flag", 32'(precise_o), 32'd1);
            if (fa != 0) begin
                chk("R4 pass", 32'(pass_o), 32'd1);
                chk("R4 pc becomes old npc", pc_o, pc + 32'd4);
                chk("R4 npc advances", npc_o, pc + 32'd8);
                chk("R4 status untouched", stat_o, st);
            end else begin
                chk("R5 fail flag", 32'(pass_o), 32'd0);
                chk("R5 pc unchanged", pc_o, pc);
                chk("R5 npc unchanged", npc_o, pc + 32'd4);
            end
        end else begin
            ok_all = 1'b1;
            for (int k = 0; k < n; k++) begin
                wait_for(1'b0);
                chk("R6 entry word in order", exec_insn_o, ent_insn(v, k));
                chk("R6 entry address in order", exec_addr_o, ent_addr(v, k));
                exec_ack_i = 1'b1; exec_ok_i = (k != fa);
                @(negedge clk);
                exec_ack_i = 1'b0;
                if (k == fa) begin
                    ok_all = 1'b0;
                    break;
                end
            end
            chk("R11 done after final ack", 32'(done_o), 32'd1);
            chk("R6 no request after end", 32'(exec_req_o), 32'd0);
            chk("R9 depth cleared", 32'(depth_o), 32'd0);
            chk("R6 pc unchanged", pc_o, pc);
            if (ok_all) begin
                chk("R7 pass", 32'(pass_o), 32'd1);
                chk("R7 status cleared", stat_o, st & ~32'h0000_301F);
            end else begin
                chk("R8 fail flag", 32'(pass_o), 32'd0);
                chk("R8 status keeps exceptions", stat_o, st & ~32'h0000_3000);
            end
        end
        @(negedge clk);
        chk("R11 done is one cycle", 32'(done_o), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 depth", 32'(depth_o), 32'd0);
        chk("R1 requests", {30'd0, fetch_req_o, exec_req_o}, 32'd0);

        for (int v = 0; v < VN; v++) run_vec(v);

        // R10: start and push ignored while a request waits
        push_n(20, 2);
        start_run(32'h5000_0000, 32'h0000_301F);
        wait_for(1'b0);
        start_i = 1'b1;
        push_i = 1'b1; push_insn_i = 32'hDEAD_BEEF; push_addr_i = 32'hDEAD_0000;
        @(negedge clk);
        start_i = 1'b0; push_i = 1'b0;
        chk("R10 depth unchanged while busy", 32'(depth_o), 32'd2);
        chk("R10 same entry presented", exec_insn_o, ent_insn(20, 0));
        @(negedge clk);
        chk("R11 request held without ack", 32'(exec_req_o), 32'd1);
        exec_ack_i = 1'b1; exec_ok_i = 1'b1;
        @(negedge clk);
        chk("R10 second entry follows", exec_insn_o, ent_insn(20, 1));
        @(negedge clk);
        exec_ack_i = 1'b0;
        chk("R10 run ends normally", 32'(done_o), 32'd1);
        chk("R9 depth cleared", 32'(depth_o), 32'd0);
        @(negedge clk);
        chk("R10 ignored start left no run", 32'(busy_o), 32'd0);

        // R3: fetch fault ends the precise run without executing
        start_run(32'h6000_0000, 32'h0000_00FF);
        wait_for(1'b1);
        fetch_ack_i = 1'b1; fetch_err_i = 1'b1;
        @(negedge clk);
        fetch_ack_i = 1'b0; fetch_err_i = 1'b0;
        chk("R3 done on fetch fault", 32'(done_o), 32'd1);
        chk("R3 fail on fetch fault", 32'(pass_o), 32'd0);
        chk("R3 no execution", 32'(exec_req_o), 32'd0);
        chk("R3 pc unchanged", pc_o, 32'h6000_0000);
        chk("R3 npc unchanged", npc_o, 32'h6000_0004);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule